// File: doc/BRIEF.md
# Byte-Serial Counter Register Port

This block gives a host an 8-bit view of one counter channel through two addresses: a data port and a control port. The counter itself sits in an attached core. The port never reads the live count byte by byte. On command it copies the count into an output latch, and the host then reads that latch one byte at a time. The counter cannot be written directly either. The host stages three bytes in a preset register and then issues a transfer command, which sends the preset value to the core as a one-cycle load strobe.

Every data-port access is steered by one shared byte pointer, and the pointer serves both preset writes and latch reads. The pointer starts at the least significant byte and moves up one byte after each access. After the most significant byte it returns to the low byte. A byte written to the control port is a command. Its top three bits pick a group, and its low five bits carry that group's payload. The groups are: transfers and clears, counter-mode configuration, I/O configuration, and index configuration. A read of the control port returns the core's status flags.

Host strobes are sampled on the rising clock edge. Read data is combinational from the current address and pointer.

Top module: `ctr_host_port`

## Requirements
- R1: After reset, the byte pointer selects the low byte, and the preset register and output latch are zero. The mode, quadrature, index and A/B-enable fields are zero, `cfg_preset_en_n` is 1, and every strobe output is low.
- R2: A write to the data port (`host_addr`=0) stores `host_wdata` into the preset byte chosen by the pointer and then advances the pointer. Byte 0 holds bits 7:0, byte 1 holds bits 15:8 and byte 2 holds bits 23:16. The staged value appears on `ctr_load_value`.
- R3: The pointer moves from byte 2 back to byte 0. A fourth data-port access after a pointer reset therefore reaches the low byte again. This holds for reads as well as writes.
- R4: A control write with group bits 7:5 = 000 and payload bit 0 set returns the pointer to byte 0.
- R5: A control write with group 000 and payload bit 4 set copies `core_count` into the output latch. Data-port reads (`host_rd`, `host_addr`=0) return the latch byte at the pointer. The latch changes on nothing else.
- R6: A control write with group 000 and payload bit 3 set raises `ctr_load` for exactly one cycle, starting at the clock edge after the write. Data-port writes never raise `ctr_load`.
- R7: Group 000 payload bit 1 raises `clr_flags` for one cycle, and payload bit 2 raises `clr_err` for one cycle. Each clear acts independently of the other.
- R8: All bits set in one group-000 command act in the same cycle. When a latch capture and a preset transfer are combined, the latch holds the count from before the load.
- R9: Group 001 loads `cfg_count_mode` from bits 2:1 and `cfg_quad_sel` from bits 4:3.
- R10: Group 011 loads `cfg_idx_sync` from bit 0 and `cfg_idx_pol` from bit 1.
- R11: Group 010 loads `cfg_ab_en` from bit 0 and the active-low `cfg_preset_en_n` from bit 1.
- R12: A read of the control port returns a flag byte. Bit 0 is borrow, bit 1 carry, bit 2 compare, bit 3 sign, bit 4 error and bit 5 up/down, and bits 7:6 are zero. Such a read leaves the pointer unchanged.
- R13: Control writes with group 100 to 111 change no configuration field, raise no strobe and leave the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_addr | input | 1 | 0 selects the data port, 1 selects the control port |
| host_wr | input | 1 | Write strobe, sampled on the rising edge |
| host_rd | input | 1 | Read strobe; ignored while `host_wr` is high |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Latch byte or flag byte for the addressed port |
| core_count | input | 24 | Live count from the attached core |
| core_borrow | input | 1 | Borrow flag from the core |
| core_carry | input | 1 | Carry flag from the core |
| core_compare | input | 1 | Compare flag from the core |
| core_sign | input | 1 | Sign flag from the core |
| core_err | input | 1 | Error flag from the core |
| core_up | input | 1 | Count direction, 1 = up |
| ctr_load | output | 1 | One-cycle strobe: load `ctr_load_value` into the counter |
| ctr_load_value | output | 24 | Preset register contents |
| clr_flags | output | 1 | One-cycle strobe clearing borrow, carry, compare and sign |
| clr_err | output | 1 | One-cycle strobe clearing the error flag |
| cfg_count_mode | output | 2 | Count mode field |
| cfg_quad_sel | output | 2 | Quadrature select field |
| cfg_idx_sync | output | 1 | Index synchronous-mode enable |
| cfg_idx_pol | output | 1 | Index polarity |
| cfg_ab_en | output | 1 | A/B input enable |
| cfg_preset_en_n | output | 1 | Active-low preset enable |

## Verification
A single command byte can order a latch capture and a preset-to-counter transfer in the same cycle, and a pointer reset can ride along. The bench models the core, which takes the preset on `ctr_load`. It first sets a live count that differs from the staged preset, then issues the combined byte. Three latch reads must return the pre-load count, and a second capture must return the preset value. Together these show that the capture and the load fell on the same edge, in the right order.

// File: rtl/ctr_port_pkg.sv
package ctr_port_pkg;

  localparam int HOST_W = 8;
  localparam int GRP_W  = 3;
  localparam int PAY_W  = HOST_W - GRP_W;
  localparam int FLAG_USED = 6;

  // Command group, carried in the top GRP_W bits of a control-port write
  typedef enum logic [GRP_W-1:0] {
    GRP_XFER  = 3'd0,
    GRP_MODE  = 3'd1,
    GRP_IOCTL = 3'd2,
    GRP_INDEX = 3'd3
  } grp_e;

  // Payload bit positions for the transfer/clear group
  localparam int XB_PTR_RST = 0;
  localparam int XB_FLAGS   = 1;
  localparam int XB_ERR     = 2;
  localparam int XB_LOAD    = 3;
  localparam int XB_LATCH   = 4;

  typedef struct packed {
    logic             ptr_rst;
    logic             flag_clr;
    logic             err_clr;
    logic             preset_ld;
    logic             latch_cap;
    logic             mode_ld;
    logic             io_ld;
    logic             idx_ld;
    logic [PAY_W-1:0] payload;
  } cmd_t;

endpackage

// File: rtl/ctr_cmd_decode.sv
module ctr_cmd_decode
  import ctr_port_pkg::*;
(
  input  logic              ctl_wr,
  input  logic [HOST_W-1:0] wbyte,
  output cmd_t              cmd
);

  logic [GRP_W-1:0] grp;
  logic [PAY_W-1:0] pay;

  assign grp = wbyte[HOST_W-1 -: GRP_W];
  assign pay = wbyte[PAY_W-1:0];

  always_comb begin
    cmd         = '0;
    cmd.payload = pay;
    if (ctl_wr) begin
      unique case (grp)
        GRP_XFER: begin
          cmd.ptr_rst   = pay[XB_PTR_RST];
          cmd.flag_clr  = pay[XB_FLAGS];
          cmd.err_clr   = pay[XB_ERR];
          cmd.preset_ld = pay[XB_LOAD];
          cmd.latch_cap = pay[XB_LATCH];
        end
        GRP_MODE:  cmd.mode_ld = 1'b1;
        GRP_IOCTL: cmd.io_ld   = 1'b1;
        GRP_INDEX: cmd.idx_ld  = 1'b1;
        default:   ;
      endcase
    end
  end

endmodule

// File: rtl/ctr_byte_path.sv
module ctr_byte_path #(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      data_wr,
  input  logic                      data_rd,
  input  logic                      ptr_clr,
  input  logic                      latch_cap,
  input  logic [BYTE_W-1:0]         wdata,
  input  logic [BYTE_W*NUM_BYTES-1:0] core_count,
  output logic [BYTE_W*NUM_BYTES-1:0] preset_val,
  output logic [BYTE_W-1:0]         rd_byte
);

  localparam int PTR_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;
  localparam int LAST  = NUM_BYTES - 1;

  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             ptr_en;
  logic [NUM_BYTES-1:0][BYTE_W-1:0] preset_q, preset_d, latch_q;

  // pointer next state: clear wins, else step with wrap
  always_comb begin
    ptr_d  = ptr_q;
    ptr_en = ptr_clr | data_wr | data_rd;
    if (ptr_clr)
      ptr_d = '0;
    else if (ptr_q == PTR_W'(LAST))
      ptr_d = '0;
    else
      ptr_d = ptr_q + 1'b1;
  end

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_slot
    assign preset_d[g] = (ptr_q == PTR_W'(g)) ? wdata : preset_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      preset_q <= '0;
      latch_q  <= '0;
    end else begin
      if (ptr_en)    ptr_q    <= ptr_d;
      if (data_wr)   preset_q <= preset_d;
      if (latch_cap) latch_q  <= core_count;
    end
  end

  assign preset_val = preset_q;
  assign rd_byte    = latch_q[ptr_q];

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= PTR_W'(LAST));                                          // R3
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr || data_rd) && !ptr_clr && ptr_q == PTR_W'(LAST) |=> ptr_q == '0); // R3
  AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_clr |=> ptr_q == '0);                                        // R4
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_cap |=> $stable(latch_q));                                // R5
  AST_PRESET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !data_wr |=> $stable(preset_val));                               // R2

endmodule

// File: rtl/ctr_cfg_regs.sv
module ctr_cfg_regs
  import ctr_port_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flag_clr,
  input  logic             err_clr,
  input  logic             preset_ld,
  input  logic             mode_ld,
  input  logic             io_ld,
  input  logic             idx_ld,
  input  logic [PAY_W-1:0] payload,
  output logic             ld_pulse,
  output logic             flag_pulse,
  output logic             err_pulse,
  output logic [1:0]       count_mode,
  output logic [1:0]       quad_sel,
  output logic             idx_sync,
  output logic             idx_pol,
  output logic             ab_en,
  output logic             preset_en_n
);

  logic [1:0] mode_d, quad_d;
  logic       sync_d, pol_d, ab_d, pen_d;

  always_comb begin
    mode_d = count_mode;
    quad_d = quad_sel;
    sync_d = idx_sync;
    pol_d  = idx_pol;
    ab_d   = ab_en;
    pen_d  = preset_en_n;
    if (mode_ld) begin
      mode_d = payload[2:1];
      quad_d = payload[4:3];
    end
    if (idx_ld) begin
      sync_d = payload[0];
      pol_d  = payload[1];
    end
    if (io_ld) begin
      ab_d  = payload[0];
      pen_d = payload[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_pulse    <= 1'b0;
      flag_pulse  <= 1'b0;
      err_pulse   <= 1'b0;
      count_mode  <= 2'b00;
      quad_sel    <= 2'b00;
      idx_sync    <= 1'b0;
      idx_pol     <= 1'b0;
      ab_en       <= 1'b0;
      preset_en_n <= 1'b1;
    end else begin
      ld_pulse   <= preset_ld;
      flag_pulse <= flag_clr;
      err_pulse  <= err_clr;
      if (mode_ld) begin
        count_mode <= mode_d;
        quad_sel   <= quad_d;
      end
      if (idx_ld) begin
        idx_sync <= sync_d;
        idx_pol  <= pol_d;
      end
      if (io_ld) begin
        ab_en       <= ab_d;
        preset_en_n <= pen_d;
      end
    end
  end

  AST_LOAD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_pulse |-> $past(preset_ld));                                  // R6
  AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    flag_pulse |-> $past(flag_clr));                                 // R7
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_ld |=> $stable(count_mode) && $stable(quad_sel));          // R9
  AST_INDEX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_ld |=> $stable(idx_sync) && $stable(idx_pol));              // R10
  AST_IO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !io_ld |=> $stable(ab_en) && $stable(preset_en_n));              // R11

endmodule

// File: rtl/ctr_host_port.sv
module ctr_host_port
  import ctr_port_pkg::*;
#(
  parameter int NUM_BYTES = 3,
  localparam int CNT_W    = HOST_W * NUM_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [HOST_W-1:0] host_wdata,
  output logic [HOST_W-1:0] host_rdata,
  input  logic [CNT_W-1:0]  core_count,
  input  logic              core_borrow,
  input  logic              core_carry,
  input  logic              core_compare,
  input  logic              core_sign,
  input  logic              core_err,
  input  logic              core_up,
  output logic              ctr_load,
  output logic [CNT_W-1:0]  ctr_load_value,
  output logic              clr_flags,
  output logic              clr_err,
  output logic [1:0]        cfg_count_mode,
  output logic [1:0]        cfg_quad_sel,
  output logic              cfg_idx_sync,
  output logic              cfg_idx_pol,
  output logic              cfg_ab_en,
  output logic              cfg_preset_en_n
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic data_wr, data_rd, ctl_wr;
  cmd_t cmd;
  logic [HOST_W-1:0] latch_byte;
  logic [HOST_W-1:0] flag_byte;

  assign data_wr = host_wr && !host_addr;
  assign ctl_wr  = host_wr &&  host_addr;
  assign data_rd = host_rd && !host_wr && !host_addr;

  ctr_cmd_decode u_dec (
    .ctl_wr (ctl_wr),
    .wbyte  (host_wdata),
    .cmd    (cmd)
  );

  ctr_byte_path #(
    .BYTE_W    (HOST_W),
    .NUM_BYTES (NUM_BYTES)
  ) u_path (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .data_wr    (data_wr),
    .data_rd    (data_rd),
    .ptr_clr    (cmd.ptr_rst),
    .latch_cap  (cmd.latch_cap),
    .wdata      (host_wdata),
    .core_count (core_count),
    .preset_val (ctr_load_value),
    .rd_byte    (latch_byte)
  );

  ctr_cfg_regs u_cfg (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .flag_clr    (cmd.flag_clr),
    .err_clr     (cmd.err_clr),
    .preset_ld   (cmd.preset_ld),
    .mode_ld     (cmd.mode_ld),
    .io_ld       (cmd.io_ld),
    .idx_ld      (cmd.idx_ld),
    .payload     (cmd.payload),
    .ld_pulse    (ctr_load),
    .flag_pulse  (clr_flags),
    .err_pulse   (clr_err),
    .count_mode  (cfg_count_mode),
    .quad_sel    (cfg_quad_sel),
    .idx_sync    (cfg_idx_sync),
    .idx_pol     (cfg_idx_pol),
    .ab_en       (cfg_ab_en),
    .preset_en_n (cfg_preset_en_n)
  );

  always_comb begin
    flag_byte    = '0;
    flag_byte[0] = core_borrow;
    flag_byte[1] = core_carry;
    flag_byte[2] = core_compare;
    flag_byte[3] = core_sign;
    flag_byte[4] = core_err;
    flag_byte[FLAG_USED-1] = core_up;
  end

  assign host_rdata = host_addr ? flag_byte : latch_byte;

  AST_LOAD_NOT_DATA: assert property (@(posedge clk) disable iff (!rst_n_int)
    data_wr |=> !ctr_load);                                          // R6
  AST_FLAG_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n_int)
    host_addr |-> host_rdata[HOST_W-1:FLAG_USED] == '0);             // R12

endmodule

// File: tb/ctr_host_port_test.sv
`timescale 1ns/1ps
module ctr_host_port_test;

  logic        clk;
  logic        rst_n;
  logic        host_addr, host_wr, host_rd;
  logic [7:0]  host_wdata, host_rdata;
  logic [23:0] core_count;
  logic        core_borrow, core_carry, core_compare, core_sign, core_err, core_up;
  logic        ctr_load, clr_flags, clr_err;
  logic [23:0] ctr_load_value;
  logic [1:0]  cfg_count_mode, cfg_quad_sel;
  logic        cfg_idx_sync, cfg_idx_pol, cfg_ab_en, cfg_preset_en_n;

  int errs   = 0;
  int checks = 0;
  bit done   = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  ctr_host_port uut (
    .clk(clk), .rst_n(rst_n),
    .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .core_count(core_count),
    .core_borrow(core_borrow), .core_carry(core_carry), .core_compare(core_compare),
    .core_sign(core_sign), .core_err(core_err), .core_up(core_up),
    .ctr_load(ctr_load), .ctr_load_value(ctr_load_value),
    .clr_flags(clr_flags), .clr_err(clr_err),
    .cfg_count_mode(cfg_count_mode), .cfg_quad_sel(cfg_quad_sel),
    .cfg_idx_sync(cfg_idx_sync), .cfg_idx_pol(cfg_idx_pol),
    .cfg_ab_en(cfg_ab_en), .cfg_preset_en_n(cfg_preset_en_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // attached core model: takes the preset on the load strobe
  always @(posedge clk) if (ctr_load) core_count <= ctr_load_value;

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares every read strobe against the queue
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (host_rd && !host_wr) begin
        checks++;
        if (exp_q.size() == 0) begin
          errs++;
          $display("FAIL unexpected read: actual=%h expected=none", host_rdata);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (host_rdata !== e) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", t, host_rdata, e);
          end
        end
      end
    end
  end

  task automatic wr_byte(logic a, logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wr = 1'b1; host_rd = 1'b0; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
    #2;
  endtask

  task automatic rd_byte(logic a, logic [7:0] e, string tag);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1; host_wr = 1'b0;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    host_rd = 1'b0;
    #2;
  endtask

  task automatic set_preset(logic [23:0] v);
    wr_byte(1'b1, 8'h01);
    wr_byte(1'b0, v[7:0]);
    wr_byte(1'b0, v[15:8]);
    wr_byte(1'b0, v[23:16]);
  endtask

  task automatic read_latch(logic [23:0] v, string tag);
    rd_byte(1'b0, v[7:0],   tag);
    rd_byte(1'b0, v[15:8],  tag);
    rd_byte(1'b0, v[23:16], tag);
  endtask

  task automatic check_cfg(string tag, logic [1:0] m, logic [1:0] q,
                           logic s, logic p, logic ab, logic pen);
    check({tag, " count_mode"}, 32'(cfg_count_mode), 32'(m));
    check({tag, " quad_sel"},   32'(cfg_quad_sel),   32'(q));
    check({tag, " idx_sync"},   32'(cfg_idx_sync),   32'(s));
    check({tag, " idx_pol"},    32'(cfg_idx_pol),    32'(p));
    check({tag, " ab_en"},      32'(cfg_ab_en),      32'(ab));
    check({tag, " preset_en_n"},32'(cfg_preset_en_n),32'(pen));
  endtask

  initial begin
    #(8 * 100000);
    errs++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    host_addr = 1'b0; host_wr = 1'b0; host_rd = 1'b0; host_wdata = 8'h00;
    core_count = 24'h000000;
    core_borrow = 0; core_carry = 0; core_compare = 0;
    core_sign = 0; core_err = 0; core_up = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2;

    // R1 reset state
    check("R1 load_value", 32'(ctr_load_value), 0);
    check("R1 ctr_load", 32'(ctr_load), 0);
    check("R1 clr_flags", 32'(clr_flags), 0);
    check("R1 clr_err", 32'(clr_err), 0);
    check_cfg("R1", 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    rd_byte(1'b0, 8'h00, "R1 latch empty");

    // R2 preset bytes LSB first; R6 no load from data writes
    wr_byte(1'b1, 8'h01);
    wr_byte(1'b0, 8'h56);
    check("R6 data write no load", 32'(ctr_load), 0);
    wr_byte(1'b0, 8'h34);
    wr_byte(1'b0, 8'h12);
    check("R2 preset staged", 32'(ctr_load_value), 32'h123456);

    // R3 fourth write wraps to low byte
    wr_byte(1'b0, 8'hAB);
    check("R3 wrap write", 32'(ctr_load_value), 32'h1234AB);

    // R4 pointer reset mid-sequence
    wr_byte(1'b0, 8'hCD);
    check("R4 byte1 written", 32'(ctr_load_value), 32'h12CDAB);
    wr_byte(1'b1, 8'h01);
    wr_byte(1'b0, 8'hEF);
    check("R4 reset to low byte", 32'(ctr_load_value), 32'h12CDEF);

    // R5 latch capture then reads; R3 read wrap
    core_count = 24'hA1B2C3;
    wr_byte(1'b1, 8'h11);
    core_count = 24'h000000;
    read_latch(24'hA1B2C3, "R5 latch read");
    rd_byte(1'b0, 8'hC3, "R3 read wrap");

    // R6 preset to counter transfer
    set_preset(24'h123456);
    wr_byte(1'b1, 8'h08);
    check("R6 load pulse", 32'(ctr_load), 1);
    check("R6 load value", 32'(ctr_load_value), 32'h123456);
    @(negedge clk); #2;
    check("R6 pulse one cycle", 32'(ctr_load), 0);
    wr_byte(1'b1, 8'h11);
    read_latch(24'h123456, "R6 counter took preset");

    // R7 independent clears
    wr_byte(1'b1, 8'h02);
    check("R7 clr_flags", 32'(clr_flags), 1);
    check("R7 clr_err idle", 32'(clr_err), 0);
    wr_byte(1'b1, 8'h04);
    check("R7 clr_err", 32'(clr_err), 1);
    check("R7 clr_flags idle", 32'(clr_flags), 0);
    @(negedge clk); #2;
    check("R7 clr_err one cycle", 32'(clr_err), 0);

    // R8 combined load + capture + pointer reset
    set_preset(24'h00FF01);
    core_count = 24'h777777;
    wr_byte(1'b1, 8'h19);
    check("R8 load pulse", 32'(ctr_load), 1);
    read_latch(24'h777777, "R8 latch has pre-load count");
    wr_byte(1'b1, 8'h11);
    read_latch(24'h00FF01, "R8 count after load");

    // R9 counter-mode group
    wr_byte(1'b1, 8'h3A);
    check_cfg("R9", 2'd1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1);

    // R10 index group
    wr_byte(1'b1, 8'h63);
    check_cfg("R10 a", 2'd1, 2'd3, 1'b1, 1'b1, 1'b0, 1'b1);
    wr_byte(1'b1, 8'h62);
    check_cfg("R10 b", 2'd1, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1);

    // R11 I/O group
    wr_byte(1'b1, 8'h41);
    check_cfg("R11", 2'd1, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0);

    // R13 unused groups ignored
    core_count = 24'h5A6B7C;
    wr_byte(1'b1, 8'h11);
    rd_byte(1'b0, 8'h7C, "R13 pre byte0");
    wr_byte(1'b1, 8'hFF);
    check("R13 no load", 32'(ctr_load), 0);
    check("R13 no clr_flags", 32'(clr_flags), 0);
    check("R13 no clr_err", 32'(clr_err), 0);
    wr_byte(1'b1, 8'h9F);
    wr_byte(1'b1, 8'hE1);
    check_cfg("R13", 2'd1, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0);
    check("R13 preset kept", 32'(ctr_load_value), 32'h00FF01);
    rd_byte(1'b0, 8'h6B, "R13 pointer kept");

    // R12 flag byte and pointer untouched by control reads
    core_borrow = 1; core_carry = 0; core_compare = 1;
    core_sign = 0; core_err = 1; core_up = 1;
    wr_byte(1'b1, 8'h11);
    rd_byte(1'b1, 8'h35, "R12 flags a");
    core_borrow = 0; core_carry = 1; core_compare = 0;
    core_sign = 1; core_err = 0; core_up = 0;
    rd_byte(1'b1, 8'h0A, "R12 flags b");
    rd_byte(1'b0, 8'h7C, "R12 pointer unmoved");

    repeat (3) @(negedge clk);
    check("scoreboard drained", 32'(exp_q.size()), 0);
    finish_run();
  end

endmodule